// File: doc/BRIEF.md
# Magnitude-Correcting Adder/Subtractor

This block is a purely combinational arithmetic unit for two unsigned operands of a configurable width, four bits by default. A single select input picks the operation. When adding, the unit returns the sum together with the end carry. When subtracting, it feeds the second operand through a bank of XOR inverters and forces a carry into the least significant position, so the main adder computes the first operand plus the bitwise inverse of the second plus one.

If that subtraction produces no end carry, the first operand was the smaller one. A second adder stage then takes the two's complement of the raw difference, and a per-bit 2-to-1 multiplexer returns the corrected value. The output is therefore always the magnitude of the difference, and a separate flag marks that the true difference is negative.

The unsigned carry flag and the signed overflow flag both come from the main adder, before any correction. This lets a caller read the same operands either as unsigned numbers or as two's-complement numbers.

Top module: `mag_addsub`

## Requirements
- R1: With sub_i = 0, result_o equals (opa_i + opb_i) modulo 2^WIDTH.
- R2: With sub_i = 0, carry_o equals bit WIDTH of the full unsigned sum opa_i + opb_i.
- R3: With sub_i = 0, neg_o is 0 for every pair of operands.
- R4: With sub_i = 1 and opa_i > opb_i, result_o equals opa_i - opb_i, carry_o is 1 and neg_o is 0.
- R5: With sub_i = 1 and opa_i < opb_i, result_o equals opb_i - opa_i, carry_o is 0 and neg_o is 1.
- R6: With sub_i = 1 and opa_i = opb_i, result_o is 0, carry_o is 1 and neg_o is 0.
- R7: With sub_i = 0, ovf_o is 1 exactly when the sum of the operands, both read as WIDTH-bit two's-complement numbers, lies outside the range -2^(WIDTH-1) to 2^(WIDTH-1)-1.
- R8: With sub_i = 1, ovf_o is 1 exactly when opa_i minus opb_i, both read as WIDTH-bit two's-complement numbers, lies outside that same range.
- R9: All outputs depend only on the present inputs. There is no state, and each output is valid within the same clock period as the input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand (minuend when subtracting) |
| opb_i | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | Operation select: 0 adds, 1 subtracts |
| result_o | output | WIDTH | Sum, or magnitude of the difference |
| carry_o | output | 1 | End carry of the main adder, before correction |
| ovf_o | output | 1 | Signed overflow: carry into the MSB XOR carry out of the MSB |
| neg_o | output | 1 | Set when subtracting and the first operand is the smaller |

## Verification
Every result and flag is a function of the inputs alone, so each is due in the same clock period as the stimulus that produces it. The bench applies a new operand pair and select just after a rising edge. It then compares all four outputs at the following falling edge, half a period later, so the signals have settled before they are read.

With WIDTH set to 4, every operand pair is swept in both modes. Each output is compared against the integer arithmetic of the requirements. Between stimuli the bench never waits more than one cycle, so a stale output from the previous pair would show up as a mismatch.

// File: rtl/mag_addsub_pkg.sv
// Package: shared operation encoding for the magnitude-correcting adder/subtractor.
// Assumes: select bit 0 means add and 1 means subtract.
package mag_addsub_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/mag_addsub_fa.sv
// One-bit full adder cell.
// Assumes: nothing; purely combinational.
module mag_addsub_fa (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    // Sum and majority carry for one bit position.
    always_comb begin
        s_o = a_i ^ b_i ^ c_i;
        c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    end
endmodule

// File: rtl/mag_addsub_inv.sv
// Selective inverter: passes the word unchanged when inv_i is 0, inverts it when 1.
// Assumes: WIDTH >= 1.
module mag_addsub_inv #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] d_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] q_o
);
    // One XOR per bit acts as a programmable inverter.
    for (genvar g = 0; g < WIDTH; g++) begin : g_xor
        assign q_o[g] = d_i[g] ^ inv_i;
    end
endmodule

// File: rtl/mag_addsub_ripple.sv
// Ripple-carry adder built from full adder cells. It exposes the carry into the top bit
// and the carry out of it, so a caller can derive signed overflow.
// Assumes: WIDTH >= 2.
module mag_addsub_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cmsb_o,
    output logic             cout_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    // Carry chain from bit 0 upward.
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        mag_addsub_fa u_fa (
            .a_i (a_i[g]),
            .b_i (b_i[g]),
            .c_i (chain[g]),
            .s_o (sum_o[g]),
            .c_o (chain[g+1])
        );
    end

    assign cmsb_o = chain[WIDTH-1];
    assign cout_o = chain[WIDTH];
endmodule

// File: rtl/mag_addsub_mux.sv
// Word-wide 2-to-1 multiplexer, one selector per bit, built per bit position.
// Assumes: WIDTH >= 1.
module mag_addsub_mux #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] d0_i,
    input  logic [WIDTH-1:0] d1_i,
    input  logic             sel_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_sel
        assign q_o[g] = sel_i ? d1_i[g] : d0_i[g];
    end
endmodule

// File: rtl/mag_addsub.sv
// Top: unsigned adder/subtractor that returns |M-N| when subtracting.
// The main adder forms M + (N ^ sub) + sub. A second adder, with its first input tied to zero,
// two's-complements the raw result. A mux picks the corrected word when subtracting without
// an end carry. The flags come from the main adder only.
// Assumes: WIDTH >= 2; combinational, so no clock and no reset.
module mag_addsub
    import mag_addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             neg_o
);
    localparam logic [WIDTH-1:0] ZERO = '0;

    op_e              op;
    logic [WIDTH-1:0] opb_x;
    logic [WIDTH-1:0] raw;
    logic             raw_cmsb;
    logic             raw_cout;
    logic [WIDTH-1:0] raw_inv;
    logic [WIDTH-1:0] fix;
    logic             fix_cmsb;
    logic             fix_cout;
    logic             use_fix;

    assign op = op_e'(sub_i);

    // Main path: conditional inversion of the second operand.
    mag_addsub_inv #(.WIDTH(WIDTH)) u_inv_main (
        .d_i   (opb_i),
        .inv_i (op == OP_SUB),
        .q_o   (opb_x)
    );

    // Main adder; the select doubles as the carry-in that completes the two's complement.
    mag_addsub_ripple #(.WIDTH(WIDTH)) u_add_main (
        .a_i    (opa_i),
        .b_i    (opb_x),
        .cin_i  (op == OP_SUB),
        .sum_o  (raw),
        .cmsb_o (raw_cmsb),
        .cout_o (raw_cout)
    );

    // Correction path: 0 + ~raw + 1 gives the two's complement of the raw difference.
    mag_addsub_inv #(.WIDTH(WIDTH)) u_inv_fix (
        .d_i   (raw),
        .inv_i (1'b1),
        .q_o   (raw_inv)
    );

    mag_addsub_ripple #(.WIDTH(WIDTH)) u_add_fix (
        .a_i    (ZERO),
        .b_i    (raw_inv),
        .cin_i  (1'b1),
        .sum_o  (fix),
        .cmsb_o (fix_cmsb),
        .cout_o (fix_cout)
    );

    // The corrected word is chosen only when a subtraction produced no end carry.
    always_comb begin
        use_fix = (op == OP_SUB) && !raw_cout;
    end

    mag_addsub_mux #(.WIDTH(WIDTH)) u_out_mux (
        .d0_i  (raw),
        .d1_i  (fix),
        .sel_i (use_fix),
        .q_o   (result_o)
    );

    // Flags taken from the main adder, before any correction.
    always_comb begin
        carry_o = raw_cout;
        ovf_o   = raw_cmsb ^ raw_cout;
        neg_o   = use_fix;
    end

    // The correction adder's carries are not needed; fold them into an unused sink.
    logic unused_fix;
    assign unused_fix = fix_cmsb ^ fix_cout;
endmodule

// File: rtl/mag_addsub_chk.sv
// Checker: relations between inputs and outputs of mag_addsub, evaluated whenever they change.
// Assumes: the block is combinational, so immediate assertions on settled values suffice.
module mag_addsub_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             ovf_o,
    input logic             neg_o
);
    localparam int MSB = WIDTH - 1;

    // Cross-checks of outputs against operand relations.
    always_comb begin
        p_add_no_neg_r3: assert (sub_i || !neg_o);
        p_add_wrap_r2: assert (sub_i || carry_o || (result_o >= opa_i));
        p_sub_ge_r4: assert (!sub_i || neg_o || (carry_o && result_o <= opa_i));
        p_sub_lt_r5: assert (!sub_i || !neg_o || (!carry_o && result_o <= opb_i && result_o != '0));
        p_sub_eq_r6: assert (!(sub_i && opa_i == opb_i) || (result_o == '0 && !neg_o));
        p_add_ovf_sign_r7: assert (sub_i || !ovf_o || (opa_i[MSB] == opb_i[MSB]));
        p_sub_ovf_sign_r8: assert (!sub_i || !ovf_o || (opa_i[MSB] != opb_i[MSB]));
    end
endmodule

bind mag_addsub mag_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .sub_i    (sub_i),
    .result_o (result_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o),
    .neg_o    (neg_o)
);

// File: tb/test_mag_addsub.sv
// Exhaustive bench: every operand pair in both modes at WIDTH = 4.
module test_mag_addsub;
    localparam int  W        = 4;
    localparam int  SPAN     = 1 << W;
    localparam time CLK_PER  = 10ns;
    localparam int  WDOG_CYC = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         sub = 1'b0;
    logic [W-1:0] res;
    logic         cy;
    logic         ov;
    logic         ng;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    mag_addsub #(.WIDTH(W)) i_mag_addsub (
        .opa_i    (opa),
        .opb_i    (opb),
        .sub_i    (sub),
        .result_o (res),
        .carry_o  (cy),
        .ovf_o    (ov),
        .neg_o    (ng)
    );

    // Compare one value and record the outcome.
    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: a=%0d b=%0d sub=%0d actual=%0d expected=%0d",
                     req, what, opa, opb, sub, act, exp);
        end
    endtask

    function automatic int to_signed(input int v);
        return (v >= SPAN/2) ? v - SPAN : v;
    endfunction

    initial begin
        // Reset phase: inputs held at zero; R9 says outputs follow inputs directly.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset result", int'(res), 0);
        chk("R9", "reset carry", int'(cy), 0);
        chk("R9", "reset ovf", int'(ov), 0);
        chk("R3", "reset neg", int'(ng), 0);
        rst_n = 1'b1;

        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < SPAN; a++) begin
                for (int b = 0; b < SPAN; b++) begin
                    int e_res, e_cy, e_ng, e_ov, sr;
                    @(posedge clk);
                    opa = W'(a);
                    opb = W'(b);
                    sub = s[0];
                    if (s == 0) begin
                        e_res = (a + b) % SPAN;
                        e_cy  = ((a + b) >= SPAN) ? 1 : 0;
                        e_ng  = 0;
                        sr    = to_signed(a) + to_signed(b);
                    end else begin
                        e_res = (a >= b) ? a - b : b - a;
                        e_cy  = (a >= b) ? 1 : 0;
                        e_ng  = (a < b) ? 1 : 0;
                        sr    = to_signed(a) - to_signed(b);
                    end
                    e_ov = (sr > SPAN/2 - 1 || sr < -(SPAN/2)) ? 1 : 0;
                    @(negedge clk);
                    if (s == 0) begin
                        chk("R1", "sum", int'(res), e_res);
                        chk("R2", "carry", int'(cy), e_cy);
                        chk("R3", "neg", int'(ng), e_ng);
                        chk("R7", "ovf", int'(ov), e_ov);
                    end else if (a > b) begin
                        chk("R4", "diff", int'(res), e_res);
                        chk("R4", "carry", int'(cy), e_cy);
                        chk("R4", "neg", int'(ng), e_ng);
                        chk("R8", "ovf", int'(ov), e_ov);
                    end else if (a < b) begin
                        chk("R5", "magnitude", int'(res), e_res);
                        chk("R5", "carry", int'(cy), e_cy);
                        chk("R5", "neg", int'(ng), e_ng);
                        chk("R8", "ovf", int'(ov), e_ov);
                    end else begin
                        chk("R6", "zero", int'(res), e_res);
                        chk("R6", "carry", int'(cy), e_cy);
                        chk("R6", "neg", int'(ng), e_ng);
                        chk("R8", "ovf", int'(ov), e_ov);
                    end
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule